// File: doc/BRIEF.md
# Extended Integer Divide Unit

A multi-cycle integer divider for a 64-bit execution pipeline. It covers truncating divide, extended divide (the first operand is moved up by the operand width before dividing) and modulo, in signed or unsigned form, on full 64-bit operands or on the low 32 bits. Any case whose result cannot be represented, and any division by zero, gives a result of zero and raises an overflow indication.

An operation enters through a valid/ready handshake. `in_ready` is high only while the unit is idle. An operand set moves in on a rising edge where `in_valid` and `in_ready` are both high. While an operation is in flight, `in_ready` stays low and the unit does not look at its inputs. Results leave without back-pressure: `done` is high for exactly one cycle, and the consumer must take `result`, `cr` and the overflow bits in that cycle. The outputs hold their values until the next completion.

Along with the result, the unit builds a 4-bit condition field (bit 3 negative, bit 2 positive, bit 1 zero, bit 0 summary overflow) and new overflow, 32-bit overflow and summary-overflow bits. When the overflow-enable flag is set, it asserts a write enable for the overflow bits. A 32-bit-mode flag limits the sign and zero tests of the condition field to the low word.

Top module: `idiv_unit`

## Requirements
- R1: `in_ready` is high exactly when the unit is idle. An operation is accepted on an edge where `in_valid` and `in_ready` are both high. Inputs presented while the unit is busy have no effect on the operation in flight.
- R2: `busy` is high from the accept edge until completion. `done` rises on the 129th rising edge after the accept edge (2×64 iteration steps plus one finishing edge) and stays high for one cycle only.
- R3: A plain divide (`in_mod`=0, `in_ext`=0) returns the quotient truncated toward zero: two's-complement when `in_signed`=1, unsigned otherwise. Examples: -4329874/43879 signed is -98, and the same bits unsigned give 0x17E5A119B9170.
- R4: Modulo (`in_mod`=1) returns the remainder, which takes the sign of the dividend in signed form. Example: -4329874 mod 43879 is -29732 when signed and 39518 when unsigned.
- R5: An extended divide (`in_ext`=1, `in_mod`=0) divides the first operand shifted left by the operand width (64, or 32 in word form). Examples: unsigned 2/3 gives 0xAAAAAAAAAAAAAAAA, and 31/157 gives 0x328C3AB35CF15328. `in_ext` has no effect on modulo.
- R6: When a quotient does not fit the signed or unsigned range of the operand width, the result is 0. Example: extended divide of 0x56789A by 0x1234 gives 0.
- R7: A divisor of zero gives a result of 0 for every operation and width.
- R8: Signed divide and signed modulo of the most negative value by -1 both give 0. The unsigned forms treat the same bits as unsigned: extended divide gives 0x8000000000000000, and modulo returns the dividend.
- R9: Word forms (`in_word`=1) use only bits 31:0 of each operand. The 32-bit result is sign-extended to 64 bits for signed forms and zero-extended for unsigned forms.
- R10: On a normal completion with `in_oe`=1, `xer_we` pulses with `done`, `ov` and `ov32` are 0, and `so` equals `in_so`. With `in_oe`=0, `xer_we` stays 0.
- R11: On a zero divisor or an unrepresentable quotient with `in_oe`=1, `ov` and `ov32` are 1 and `so` is 1. With `in_oe`=0, `so` equals `in_so`.
- R12: On a normal completion, `cr` = {neg, pos, zero, `in_so`}. neg is the result's sign bit, zero means the result is 0, and pos means neither. With `in_m32`=1, both tests use bits 31:0 only.
- R13: On a zero divisor or an unrepresentable quotient, `cr` = {3'b001, updated `so`}.
- R14: A synchronous reset clears `busy`, `done` and `xer_we`, and it abandons any operation in flight so that it never completes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operation offered |
| in_ready | output | 1 | Unit idle and able to accept |
| in_mod | input | 1 | 1 = modulo, 0 = divide |
| in_signed | input | 1 | Two's-complement operands |
| in_word | input | 1 | Operate on bits 31:0 |
| in_ext | input | 1 | Extended divide (divide only) |
| in_oe | input | 1 | Enable overflow bit update |
| in_m32 | input | 1 | 32-bit mode for condition tests |
| in_so | input | 1 | Current summary-overflow bit |
| in_a | input | 64 | Dividend operand |
| in_b | input | 64 | Divisor operand |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| result | output | 64 | Quotient or remainder |
| cr | output | 4 | Condition field {neg, pos, zero, so} |
| xer_we | output | 1 | Overflow bits write enable |
| ov | output | 1 | Overflow |
| ov32 | output | 1 | 32-bit overflow |
| so | output | 1 | Updated summary overflow |

## Verification
The hardest results to reach are the ones where the quotient exists but does not fit. This happens in signed extended divides whose shifted dividend just exceeds the positive range, and in the most-negative-by-minus-one pair in each width. Random operands almost never produce these cases, so the stimulus table names them directly next to their unsigned twins, which must not overflow. A second hard case is a condition field in 32-bit mode that disagrees with the 64-bit view. To produce it, dividends are chosen so that the quotient is 0x1_0000_0000 or 0x8000_0000, and the same division runs in both modes.

// File: rtl/idiv_pkg.sv
package idiv_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_FIN} idiv_state_e;

  typedef struct packed {
    logic is_mod;
    logic is_signed;
    logic is_word;
    logic oe;
    logic m32;
    logic so;
    logic neg_q;
    logic neg_r;
    logic bz;
  } idiv_ctl_t;
endpackage

// File: rtl/idiv_prep.sv
module idiv_prep #(
  parameter int W = 64
) (
  input  logic [W-1:0]   a_i,
  input  logic [W-1:0]   b_i,
  input  logic           sgn_i,
  input  logic           word_i,
  input  logic           ext_i,
  input  logic           mod_i,
  output logic [2*W-1:0] dvd_o,
  output logic [W-1:0]   dvs_o,
  output logic           neg_q_o,
  output logic           neg_r_o,
  output logic           bz_o
);
  localparam int HW = W / 2;
  localparam int DW = 2 * W;

  logic [W-1:0] aw, bw, ma, mb;
  logic         sa, sb;
  int           sh;

  always_comb begin
    // narrow operands to the low half for word forms
    aw = word_i ? (sgn_i ? {{HW{a_i[HW-1]}}, a_i[HW-1:0]} : {{HW{1'b0}}, a_i[HW-1:0]}) : a_i;
    bw = word_i ? (sgn_i ? {{HW{b_i[HW-1]}}, b_i[HW-1:0]} : {{HW{1'b0}}, b_i[HW-1:0]}) : b_i;
    sa = sgn_i & aw[W-1];
    sb = sgn_i & bw[W-1];
    ma = sa ? (~aw + 1'b1) : aw;
    mb = sb ? (~bw + 1'b1) : bw;
    // extended divide moves the dividend up by the operand width
    sh = (ext_i && !mod_i) ? (word_i ? HW : W) : 0;
    dvd_o   = DW'({{W{1'b0}}, ma} << sh);
    dvs_o   = mb;
    neg_q_o = sa ^ sb;
    neg_r_o = sa;
    bz_o    = (bw == '0);
  end
endmodule

// File: rtl/idiv_core.sv
module idiv_core #(
  parameter int W = 64
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           load,
  input  logic           step,
  input  logic [2*W-1:0] dvd_i,
  input  logic [W-1:0]   dvs_i,
  output logic [2*W-1:0] quo_o,
  output logic [W-1:0]   rem_o
);
  localparam int DW = 2 * W;

  logic [DW-1:0] dq;
  logic [W-1:0]  rq, dv;
  logic [W:0]    shl, diff;
  logic          take;

  always_comb begin
    shl  = {rq, dq[DW-1]};
    diff = shl - {1'b0, dv};
    take = ~diff[W];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dq <= '0;
      rq <= '0;
      dv <= '0;
    end else if (load) begin
      dq <= dvd_i;
      rq <= '0;
      dv <= dvs_i;
    end else if (step) begin
      rq <= take ? diff[W-1:0] : shl[W-1:0];
      dq <= {dq[DW-2:0], take};
    end
  end

  assign quo_o = dq;
  assign rem_o = rq;

  // R3
  rem_bound_chk: assert property (@(posedge clk) disable iff (rst)
    (dv != '0) |-> (rq < dv));
endmodule

// File: rtl/idiv_fix.sv
module idiv_fix #(
  parameter int W = 64
) (
  input  logic [2*W-1:0] quo_i,
  input  logic [W-1:0]   rem_i,
  input  logic           is_mod,
  input  logic           is_signed,
  input  logic           is_word,
  input  logic           neg_q,
  input  logic           neg_r,
  input  logic           bz,
  input  logic           oe,
  input  logic           m32,
  input  logic           so_in,
  output logic [W-1:0]   res_o,
  output logic [3:0]     cr_o,
  output logic           ovf_o,
  output logic           so_o
);
  localparam int HW = W / 2;
  localparam int DW = 2 * W;
  localparam logic [DW-1:0] ONE = {{(DW-1){1'b0}}, 1'b1};

  logic [DW-1:0] lim;
  logic [W-1:0]  mag, val, wide;
  logic          neg, ovf, sbit, zero;
  int            wd;

  always_comb begin
    wd  = is_word ? HW : W;
    lim = is_signed ? ((ONE << (wd - 1)) - {{(DW-1){1'b0}}, ~neg_q})
                    : ((ONE << wd) - ONE);
    ovf = bz | (quo_i > lim);
    mag = is_mod ? rem_i : quo_i[W-1:0];
    neg = is_mod ? neg_r : neg_q;
    val = neg ? (~mag + 1'b1) : mag;
    if (is_word)
      wide = is_signed ? {{HW{val[HW-1]}}, val[HW-1:0]} : {{HW{1'b0}}, val[HW-1:0]};
    else
      wide = val;
    res_o = ovf ? '0 : wide;
    sbit  = m32 ? res_o[HW-1] : res_o[W-1];
    zero  = m32 ? (res_o[HW-1:0] == '0) : (res_o == '0);
    so_o  = so_in | (oe & ovf);
    ovf_o = ovf;
    cr_o  = ovf ? {3'b001, so_o} : {sbit, ~sbit & ~zero, zero, so_in};
  end
endmodule

// File: rtl/idiv_unit.sv
module idiv_unit #(
  parameter int W = 64
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic         in_mod,
  input  logic         in_signed,
  input  logic         in_word,
  input  logic         in_ext,
  input  logic         in_oe,
  input  logic         in_m32,
  input  logic         in_so,
  input  logic [W-1:0] in_a,
  input  logic [W-1:0] in_b,
  output logic         busy,
  output logic         done,
  output logic [W-1:0] result,
  output logic [3:0]   cr,
  output logic         xer_we,
  output logic         ov,
  output logic         ov32,
  output logic         so
);
  import idiv_pkg::*;

  localparam int DW    = 2 * W;
  localparam int STEPS = DW;
  localparam int CW    = $clog2(STEPS);
  localparam logic [CW-1:0] LAST = CW'(STEPS - 1);

  idiv_state_e   state;
  logic [CW-1:0] cnt;
  idiv_ctl_t     ctl_q, ctl_d;
  logic [DW-1:0] p_dvd, quo;
  logic [W-1:0]  p_dvs, rem, fx_res;
  logic          p_negq, p_negr, p_bz, accept;
  logic [3:0]    fx_cr;
  logic          fx_ovf, fx_so;
  logic          done_q, xer_we_q, ov_q, so_q;
  logic [W-1:0]  res_q;
  logic [3:0]    cr_q;

  assign in_ready = (state == ST_IDLE);
  assign accept   = in_valid & in_ready;

  idiv_prep #(.W(W)) u_prep (
    .a_i(in_a), .b_i(in_b), .sgn_i(in_signed), .word_i(in_word),
    .ext_i(in_ext), .mod_i(in_mod), .dvd_o(p_dvd), .dvs_o(p_dvs),
    .neg_q_o(p_negq), .neg_r_o(p_negr), .bz_o(p_bz)
  );

  assign ctl_d = '{is_mod: in_mod, is_signed: in_signed, is_word: in_word,
                   oe: in_oe, m32: in_m32, so: in_so,
                   neg_q: p_negq, neg_r: p_negr, bz: p_bz};

  idiv_core #(.W(W)) u_core (
    .clk(clk), .rst(rst), .load(accept), .step(state == ST_RUN),
    .dvd_i(p_dvd), .dvs_i(p_dvs), .quo_o(quo), .rem_o(rem)
  );

  idiv_fix #(.W(W)) u_fix (
    .quo_i(quo), .rem_i(rem), .is_mod(ctl_q.is_mod),
    .is_signed(ctl_q.is_signed), .is_word(ctl_q.is_word),
    .neg_q(ctl_q.neg_q), .neg_r(ctl_q.neg_r), .bz(ctl_q.bz),
    .oe(ctl_q.oe), .m32(ctl_q.m32), .so_in(ctl_q.so),
    .res_o(fx_res), .cr_o(fx_cr), .ovf_o(fx_ovf), .so_o(fx_so)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      cnt      <= '0;
      ctl_q    <= '0;
      done_q   <= 1'b0;
      xer_we_q <= 1'b0;
      res_q    <= '0;
      cr_q     <= '0;
      ov_q     <= 1'b0;
      so_q     <= 1'b0;
    end else begin
      done_q   <= 1'b0;
      xer_we_q <= 1'b0;
      case (state)
        ST_IDLE: if (accept) begin
          state <= ST_RUN;
          cnt   <= '0;
          ctl_q <= ctl_d;
        end
        ST_RUN: begin
          cnt <= cnt + 1'b1;
          if (cnt == LAST) state <= ST_FIN;
        end
        ST_FIN: begin
          state    <= ST_IDLE;
          done_q   <= 1'b1;
          xer_we_q <= ctl_q.oe;
          res_q    <= fx_res;
          cr_q     <= fx_cr;
          ov_q     <= fx_ovf;
          so_q     <= fx_so;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign busy   = (state != ST_IDLE);
  assign done   = done_q;
  assign result = res_q;
  assign cr     = cr_q;
  assign xer_we = xer_we_q;
  assign ov     = ov_q;
  assign ov32   = ov_q;
  assign so     = so_q;

  // R2
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done_q |=> !done_q);
  // R7
  zero_div_chk: assert property (@(posedge clk) disable iff (rst)
    (done_q && ctl_q.bz) |-> (res_q == '0));
  // R10
  xer_we_chk: assert property (@(posedge clk) disable iff (rst)
    xer_we_q |-> done_q);
  // R12
  cr_class_chk: assert property (@(posedge clk) disable iff (rst)
    done_q |-> ($countones(cr_q[3:1]) == 1));
  // R13
  ovf_cr_chk: assert property (@(posedge clk) disable iff (rst)
    (done_q && ov_q) |-> (cr_q[3:1] == 3'b001));
  // R14
  reset_idle_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (!done_q && !busy && !xer_we_q));
endmodule

// File: tb/idiv_unit_test.sv
module idiv_unit_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0, in_mod = 1'b0, in_signed = 1'b0, in_word = 1'b0;
  logic        in_ext = 1'b0, in_oe = 1'b0, in_m32 = 1'b0, in_so = 1'b0;
  logic [63:0] in_a = '0, in_b = '0;
  logic        in_ready, busy, done, xer_we, ov, ov32, so;
  logic [63:0] result;
  logic [3:0]  cr;

  int checks = 0;
  int errors = 0;
  int last_lat = 0;

  always #10 clk = ~clk;

  idiv_unit uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_mod(in_mod), .in_signed(in_signed), .in_word(in_word), .in_ext(in_ext),
    .in_oe(in_oe), .in_m32(in_m32), .in_so(in_so), .in_a(in_a), .in_b(in_b),
    .busy(busy), .done(done), .result(result), .cr(cr), .xer_we(xer_we),
    .ov(ov), .ov32(ov32), .so(so)
  );

  localparam logic [63:0] NA  = 64'hFFFFFFFFFFBDEE6E; // -4329874
  localparam logic [63:0] PB  = 64'd43879;
  localparam logic [63:0] NB  = 64'hFFFFFFFFFFFF5499; // -43879
  localparam logic [63:0] MN  = 64'h8000000000000000;
  localparam logic [63:0] M1  = 64'hFFFFFFFFFFFFFFFF;
  localparam logic [63:0] Q1  = 64'h56789A;
  localparam logic [63:0] D1  = 64'h1234;

  // f = {mod, signed, word, ext}
  typedef struct packed {
    logic [63:0] a;
    logic [63:0] b;
    logic [3:0]  f;
    logic [63:0] e;
    logic [7:0]  r;
  } vec_t;

  localparam int NV = 39;
  localparam vec_t VECS [NV] = '{
    '{64'd0, 64'd0, 4'b0100, 64'd0, 8'd7},                // R7
    '{64'd5, 64'd0, 4'b1110, 64'd0, 8'd7},                // R7
    '{64'd7, 64'd0, 4'b0001, 64'd0, 8'd7},                // R7
    '{Q1, D1, 4'b0100, 64'h4C0, 8'd3},                    // R3
    '{Q1, D1, 4'b0000, 64'h4C0, 8'd3},                    // R3
    '{NA, PB, 4'b0100, 64'hFFFFFFFFFFFFFF9E, 8'd3},       // R3
    '{NA, PB, 4'b0000, 64'h17E5A119B9170, 8'd3},          // R3
    '{NA, NB, 4'b0100, 64'd98, 8'd3},                     // R3
    '{NA, NB, 4'b0000, 64'd0, 8'd3},                      // R3
    '{Q1, D1, 4'b1100, 64'h19A, 8'd4},                    // R4
    '{NA, PB, 4'b1100, 64'hFFFFFFFFFFFF8BDC, 8'd4},       // R4
    '{NA, PB, 4'b1000, 64'd39518, 8'd4},                  // R4
    '{NA, NB, 4'b1000, NA, 8'd4},                         // R4
    '{NA, NB, 4'b1100, 64'hFFFFFFFFFFFF8BDC, 8'd4},       // R4
    '{64'd2, 64'd3, 4'b0001, 64'hAAAAAAAAAAAAAAAA, 8'd5}, // R5
    '{64'd31, 64'd157, 4'b0101, 64'h328C3AB35CF15328, 8'd5}, // R5
    '{64'd31, 64'd157, 4'b0001, 64'h328C3AB35CF15328, 8'd5}, // R5
    '{NA, NB, 4'b0001, 64'hFFFFFFFFFFBE99D4, 8'd5},       // R5
    '{Q1, D1, 4'b1001, 64'h19A, 8'd5},                    // R5 ext ignored by modulo
    '{64'd2, 64'd3, 4'b0101, 64'd0, 8'd6},                // R6
    '{Q1, D1, 4'b0001, 64'd0, 8'd6},                      // R6
    '{NA, PB, 4'b0101, 64'd0, 8'd6},                      // R6
    '{MN, M1, 4'b0100, 64'd0, 8'd8},                      // R8
    '{MN, M1, 4'b1100, 64'd0, 8'd8},                      // R8
    '{MN, M1, 4'b0000, 64'd0, 8'd8},                      // R8
    '{MN, M1, 4'b0001, MN, 8'd8},                         // R8
    '{MN, M1, 4'b1000, MN, 8'd8},                         // R8
    '{NA, PB, 4'b0010, 64'h17DF7, 8'd9},                  // R9
    '{NA, PB, 4'b1010, 64'd17165, 8'd9},                  // R9
    '{NA, PB, 4'b0110, 64'hFFFFFFFFFFFFFF9E, 8'd9},       // R9
    '{NA, PB, 4'b1110, 64'hFFFFFFFFFFFF8BDC, 8'd9},       // R9
    '{NA, NB, 4'b0011, 64'h00000000FFBE99A9, 8'd9},       // R9
    '{NA, NB, 4'b1010, 64'h00000000FFBDEE6E, 8'd9},       // R9
    '{64'd2, 64'd3, 4'b0011, 64'h00000000AAAAAAAA, 8'd9}, // R9
    '{64'd31, 64'd157, 4'b0111, 64'h00000000328C3AB3, 8'd9}, // R9
    '{64'h80000000, M1, 4'b0110, 64'd0, 8'd8},            // R8 word
    '{64'h80000000, M1, 4'b0011, 64'h80000000, 8'd9},     // R9
    '{64'h123456780056789A, 64'hABCD000000001234, 4'b0010, 64'h4C0, 8'd9}, // R9
    '{64'h80000000, M1, 4'b1010, 64'h80000000, 8'd9}      // R9
  };

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wait_done();
    int lat = 0;
    do begin
      @(posedge clk); #2;
      lat++;
    end while (!done && lat < 400);
    last_lat = lat;
  endtask

  task automatic run_op(input logic [63:0] a, input logic [63:0] b, input logic [3:0] f,
                        input logic oe, input logic m32, input logic s);
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    in_a = a; in_b = b;
    in_mod = f[3]; in_signed = f[2]; in_word = f[1]; in_ext = f[0];
    in_oe = oe; in_m32 = m32; in_so = s;
    in_valid = 1'b1;
    @(posedge clk); #2;
    in_valid = 1'b0;
    wait_done();
  endtask

  initial begin
    #(20 * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #2;
    // R14 reset state
    chk("R14 busy after reset", 64'(busy), 64'd0);
    chk("R14 done after reset", 64'(done), 64'd0);
    chk("R14 xer_we after reset", 64'(xer_we), 64'd0);
    chk("R1 ready after reset", 64'(in_ready), 64'd1);
    @(negedge clk) rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      run_op(VECS[i].a, VECS[i].b, VECS[i].f, 1'b0, 1'b0, 1'b0);
      chk($sformatf("R%0d row %0d result", VECS[i].r, i), result, VECS[i].e);
      if (i == 0) chk("R2 latency", 64'(last_lat), 64'd129);
    end

    // R2 pulse width and R1 ready after completion
    @(posedge clk); #2;
    chk("R2 done one cycle", 64'(done), 64'd0);
    chk("R1 ready when idle", 64'(in_ready), 64'd1);

    // R1 inputs while busy are ignored
    @(negedge clk);
    in_a = Q1; in_b = D1; in_mod = 1'b0; in_signed = 1'b0; in_word = 1'b0; in_ext = 1'b0;
    in_oe = 1'b0; in_m32 = 1'b0; in_so = 1'b0; in_valid = 1'b1;
    @(posedge clk); #2;
    in_a = 64'd100; in_b = 64'd1; in_mod = 1'b1; in_signed = 1'b1;
    chk("R1 ready low while busy", 64'(in_ready), 64'd0);
    chk("R2 busy while running", 64'(busy), 64'd1);
    repeat (20) @(posedge clk);
    #2 in_valid = 1'b0;
    wait_done();
    chk("R1 result unaffected", result, 64'h4C0);
    chk("R2 latency second op", 64'(last_lat), 64'd109);

    // R10 R12 normal, oe set, so set
    run_op(Q1, D1, 4'b0100, 1'b1, 1'b0, 1'b1);
    chk("R12 cr positive", 64'(cr), 64'b0101);
    chk("R10 xer_we", 64'(xer_we), 64'd1);
    chk("R10 ov", 64'(ov), 64'd0);
    chk("R10 ov32", 64'(ov32), 64'd0);
    chk("R10 so kept", 64'(so), 64'd1);
    // R12 negative, oe clear
    run_op(NA, PB, 4'b0100, 1'b0, 1'b0, 1'b0);
    chk("R12 cr negative", 64'(cr), 64'b1000);
    chk("R10 no xer_we", 64'(xer_we), 64'd0);
    // R12 32-bit mode tests
    run_op(64'h200000000, 64'd2, 4'b0000, 1'b0, 1'b1, 1'b0);
    chk("R12 m32 zero", 64'(cr), 64'b0010);
    run_op(64'h200000000, 64'd2, 4'b0000, 1'b0, 1'b0, 1'b0);
    chk("R12 m64 positive", 64'(cr), 64'b0100);
    run_op(64'h100000000, 64'd2, 4'b0000, 1'b0, 1'b1, 1'b0);
    chk("R12 m32 negative", 64'(cr), 64'b1000);
    run_op(64'h100000000, 64'd2, 4'b0000, 1'b0, 1'b0, 1'b0);
    chk("R12 m64 positive b", 64'(cr), 64'b0100);
    run_op(64'd0, 64'd5, 4'b0100, 1'b1, 1'b0, 1'b0);
    chk("R12 cr zero", 64'(cr), 64'b0010);
    chk("R10 ov zero result", 64'(ov), 64'd0);
    // R11 R13 divide by zero with oe
    run_op(64'd9, 64'd0, 4'b0100, 1'b1, 1'b0, 1'b0);
    chk("R7 result", result, 64'd0);
    chk("R11 ov", 64'(ov), 64'd1);
    chk("R11 ov32", 64'(ov32), 64'd1);
    chk("R11 so", 64'(so), 64'd1);
    chk("R11 xer_we", 64'(xer_we), 64'd1);
    chk("R13 cr", 64'(cr), 64'b0011);
    // R13 overflow without oe
    run_op(MN, M1, 4'b0100, 1'b0, 1'b0, 1'b0);
    chk("R13 cr no oe", 64'(cr), 64'b0010);
    chk("R11 so unchanged", 64'(so), 64'd0);
    chk("R10 xer_we clear", 64'(xer_we), 64'd0);
    run_op(MN, M1, 4'b0100, 1'b1, 1'b0, 1'b1);
    chk("R13 cr so set", 64'(cr), 64'b0011);
    chk("R11 ov overflow", 64'(ov), 64'd1);

    // R14 reset mid-operation
    @(negedge clk);
    in_a = Q1; in_b = D1; in_mod = 1'b0; in_signed = 1'b0; in_word = 1'b0; in_ext = 1'b0;
    in_valid = 1'b1;
    @(posedge clk); #2 in_valid = 1'b0;
    repeat (10) @(posedge clk);
    @(negedge clk) rst = 1'b1;
    @(posedge clk); #2;
    chk("R14 busy cleared", 64'(busy), 64'd0);
    chk("R14 done cleared", 64'(done), 64'd0);
    chk("R14 ready", 64'(in_ready), 64'd1);
    @(negedge clk) rst = 1'b0;
    begin
      logic seen = 1'b0;
      repeat (150) begin
        @(posedge clk); #2;
        if (done) seen = 1'b1;
      end
      chk("R14 no completion after reset", 64'(seen), 64'd0);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule